// File: doc/BRIEF.md
# LED Row Compare-PWM Driver

This block produces one row of serial pixel data for an RGB LED matrix that has no internal double buffer. Each pass takes 32 pixels from a valid/ready stream. A pixel beat carries an 8-bit intensity for each of the three colours. The block compares every intensity against a shared reference level and keeps the 32 one-bit results per colour in a result bank. The reference then steps forward. Over 256 passes this gives each pixel a duty cycle proportional to its intensity.

Once a bank holds a complete pass, the sequencer does four things in order:
- It disables the panel output.
- It shifts the three colour bits out together on one shared shift clock, at half the system clock rate.
- It pulses latch.
- It re-enables the output.

There are two result banks. The next pass can be captured while the previous one is being shifted. Input is stalled only when both banks hold passes that have not yet been shifted.

Top module: `rgb_row_pwm_driver`

## Requirements
- R1: For every pixel and every colour, the stored and shifted bit is 1 exactly when the 8-bit intensity is strictly greater than the current reference level. An intensity equal to the reference gives 0.
- R2: Each group of 32 accepted beats forms one pass, and the beat order gives the column order. Colour k sits in `in_pix[8k+7:8k]` and is shifted out on `ser_data[k]`. Column 0 is shifted first.
- R3: The reference level is 0 after reset. It rises by one after each completed pass and wraps from 255 to 0.
- R4: No bit of a pass is shifted before all 32 of its beats have been accepted.
- R5: Each column bit is presented for two clock cycles: one with `ser_clk` low, then one with `ser_clk` high. All three `ser_data` lines hold the same column during both cycles.
- R6: `disp_en` is low from the first shift cycle through the latch cycle. Each blanking window lasts exactly 2*32+1 = 65 cycles.
- R7: `ser_latch` is a single-cycle pulse in the cycle right after the 32nd `ser_clk` high cycle, with `disp_en` still low. Exactly 32 `ser_clk` pulses come before each latch.
- R8: `in_ready` is low exactly when two captured passes have not yet been released. A pass is released when `disp_en` rises after its latch.
- R9: While `rst_n` is low and right after it is released, `disp_en` is 1 and `ser_clk`, `ser_latch` and `ser_data` are 0. `in_ready` is 1 after reset.
- R10: If another captured pass is waiting when `disp_en` rises, `disp_en` goes low again in the very next cycle, so output is enabled for only one cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Pixel beat valid |
| in_ready | output | 1 | Pixel beat accepted when high with in_valid |
| in_pix | input | 24 | Three 8-bit colour intensities, colour k in bits 8k+7:8k |
| ser_data | output | 3 | Serial colour bits, one per colour |
| ser_clk | output | 1 | Shared shift clock, half system rate |
| ser_latch | output | 1 | One-cycle latch pulse |
| disp_en | output | 1 | Panel output enable, high = lit |

## Verification
The bench runs 260 passes. That carries the reference through its wrap from 255 to 0, and the pixel pattern makes each colour hit intensities equal to, one above and one below the reference.

The checks target the following design faults:
- A `>=` compare would light columns that should stay dark.
- A reversed shift order would scramble the column order.
- A reference that does not wrap would leave rows dark after pass 255.
- A full-flag or pointer slip in the double buffer would either shift a half-filled bank or let `in_ready` drop while a bank is free.

The bench also measures each blanking window. An extra idle cycle between back-to-back passes, or a latch pulse at the wrong position, changes that count.

// File: rtl/rpd_pkg.sv
package rpd_pkg;
  typedef enum logic [1:0] {
    SH_IDLE  = 2'd0,
    SH_LO    = 2'd1,
    SH_HI    = 2'd2,
    SH_LATCH = 2'd3
  } sh_state_t;
endpackage

// File: rtl/rpd_capture.sv
module rpd_capture #(
  parameter int COLS = 32,
  parameter int IW   = 8,
  parameter int NCH  = 3
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  input  logic [NCH*IW-1:0]       in_pix,
  input  logic [1:0]              bank_full,
  output logic                    in_ready,
  output logic                    wr_en,
  output logic                    wr_last,
  output logic                    wr_bank,
  output logic [$clog2(COLS)-1:0] wr_col,
  output logic [NCH-1:0]          wr_bits
);
  localparam int CW = $clog2(COLS);

  logic [CW-1:0] col_q, col_d;
  logic [IW-1:0] ref_q, ref_d;
  logic          bank_q, bank_d;
  logic          last_col;

  assign in_ready = ~bank_full[bank_q];
  assign wr_en    = in_valid & in_ready;
  assign last_col = (col_q == CW'(COLS - 1));
  assign wr_last  = last_col;
  assign wr_bank  = bank_q;
  assign wr_col   = col_q;

  for (genvar ch = 0; ch < NCH; ch++) begin : g_cmp
    assign wr_bits[ch] = (in_pix[ch*IW +: IW] > ref_q);
  end

  always_comb begin
    col_d  = col_q;
    ref_d  = ref_q;
    bank_d = bank_q;
    if (wr_en) begin
      if (last_col) begin
        col_d  = '0;
        ref_d  = ref_q + IW'(1);
        bank_d = ~bank_q;
      end else begin
        col_d = col_q + CW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      col_q  <= '0;
      ref_q  <= '0;
      bank_q <= 1'b0;
    end else if (wr_en) begin
      col_q  <= col_d;
      ref_q  <= ref_d;
      bank_q <= bank_d;
    end
  end

  // R3
  ref_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && last_col) |=> (ref_q == IW'($past(ref_q) + IW'(1))));

  // R2
  col_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(col_q));
endmodule

// File: rtl/rpd_bank_store.sv
module rpd_bank_store #(
  parameter int COLS = 32,
  parameter int NCH  = 3
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic                    wr_last,
  input  logic                    wr_bank,
  input  logic [$clog2(COLS)-1:0] wr_col,
  input  logic [NCH-1:0]          wr_bits,
  input  logic                    rd_bank,
  input  logic [$clog2(COLS)-1:0] rd_col,
  input  logic                    rel_en,
  output logic [1:0]              full,
  output logic [NCH-1:0]          rd_bits
);
  logic [1:0]       full_q, full_d;
  logic [2*NCH-1:0] rd_all;

  for (genvar b = 0; b < 2; b++) begin : g_bank
    for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
      logic [COLS-1:0] row_q;
      logic            row_we;
      assign row_we = wr_en && (wr_bank == 1'(b));
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          row_q <= '0;
        end else if (row_we) begin
          row_q[wr_col] <= wr_bits[ch];
        end
      end
      assign rd_all[b*NCH + ch] = row_q[rd_col];
    end
  end

  for (genvar ch = 0; ch < NCH; ch++) begin : g_rd
    assign rd_bits[ch] = rd_bank ? rd_all[NCH + ch] : rd_all[ch];
  end

  always_comb begin
    full_d = full_q;
    if (wr_en && wr_last) full_d[wr_bank] = 1'b1;
    if (rel_en)           full_d[rd_bank] = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) full_q <= 2'b00;
    else        full_q <= full_d;
  end

  assign full = full_q;

  // R8
  no_overwrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> !full_q[wr_bank]);

  // R4
  release_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rel_en |-> full_q[rd_bank]);
endmodule

// File: rtl/rpd_shifter.sv
module rpd_shifter
  import rpd_pkg::*;
#(
  parameter int COLS = 32,
  parameter int NCH  = 3
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [1:0]              bank_full,
  input  logic [NCH-1:0]          rd_bits,
  output logic                    rd_bank,
  output logic [$clog2(COLS)-1:0] rd_col,
  output logic                    rel_en,
  output logic [NCH-1:0]          ser_data,
  output logic                    ser_clk,
  output logic                    ser_latch,
  output logic                    disp_en
);
  localparam int CW = $clog2(COLS);

  sh_state_t     state_q, state_d;
  logic [CW-1:0] bit_q, bit_d;
  logic          rd_q, rd_d;
  logic          shifting;

  always_comb begin
    state_d = state_q;
    bit_d   = bit_q;
    rd_d    = rd_q;
    unique case (state_q)
      SH_IDLE: begin
        if (bank_full[rd_q]) begin
          state_d = SH_LO;
          bit_d   = '0;
        end
      end
      SH_LO: state_d = SH_HI;
      SH_HI: begin
        if (bit_q == CW'(COLS - 1)) begin
          state_d = SH_LATCH;
        end else begin
          state_d = SH_LO;
          bit_d   = bit_q + CW'(1);
        end
      end
      SH_LATCH: begin
        state_d = SH_IDLE;
        rd_d    = ~rd_q;
      end
      default: state_d = SH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SH_IDLE;
      bit_q   <= '0;
      rd_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      bit_q   <= bit_d;
      rd_q    <= rd_d;
    end
  end

  assign shifting  = (state_q == SH_LO) || (state_q == SH_HI);
  assign rd_bank   = rd_q;
  assign rd_col    = bit_q;
  assign rel_en    = (state_q == SH_LATCH);
  assign ser_data  = shifting ? rd_bits : '0;
  assign ser_clk   = (state_q == SH_HI);
  assign ser_latch = (state_q == SH_LATCH);
  assign disp_en   = (state_q == SH_IDLE);

  // R4
  shift_from_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    shifting |-> bank_full[rd_q]);

  // R5
  data_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ser_clk |-> $stable(ser_data));

  // R7
  latch_after_clk_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ser_latch) |-> $past(ser_clk));

  // R6
  enable_after_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(disp_en) |-> $past(ser_latch));
endmodule

// File: rtl/rgb_row_pwm_driver.sv
module rgb_row_pwm_driver #(
  parameter int COLS = 32,
  parameter int IW   = 8,
  parameter int NCH  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [NCH*IW-1:0] in_pix,
  output logic [NCH-1:0]    ser_data,
  output logic              ser_clk,
  output logic              ser_latch,
  output logic              disp_en
);
  localparam int CW = $clog2(COLS);

  logic          wr_en, wr_last, wr_bank, rd_bank, rel_en;
  logic [CW-1:0] wr_col, rd_col;
  logic [NCH-1:0] wr_bits, rd_bits;
  logic [1:0]    full;

  rpd_capture #(.COLS(COLS), .IW(IW), .NCH(NCH)) u_capture (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_pix(in_pix),
    .bank_full(full), .in_ready(in_ready), .wr_en(wr_en), .wr_last(wr_last),
    .wr_bank(wr_bank), .wr_col(wr_col), .wr_bits(wr_bits)
  );

  rpd_bank_store #(.COLS(COLS), .NCH(NCH)) u_store (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_last(wr_last),
    .wr_bank(wr_bank), .wr_col(wr_col), .wr_bits(wr_bits),
    .rd_bank(rd_bank), .rd_col(rd_col), .rel_en(rel_en),
    .full(full), .rd_bits(rd_bits)
  );

  rpd_shifter #(.COLS(COLS), .NCH(NCH)) u_shifter (
    .clk(clk), .rst_n(rst_n), .bank_full(full), .rd_bits(rd_bits),
    .rd_bank(rd_bank), .rd_col(rd_col), .rel_en(rel_en),
    .ser_data(ser_data), .ser_clk(ser_clk), .ser_latch(ser_latch),
    .disp_en(disp_en)
  );

  // R6
  blank_during_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ser_clk || ser_latch) |-> !disp_en);
endmodule

// File: tb/rgb_row_pwm_driver_bench.sv
module rgb_row_pwm_driver_bench;
  localparam int COLS  = 32;
  localparam int IW    = 8;
  localparam int NCH   = 3;
  localparam int NPASS = 260;

  logic              clk;
  logic              rst_n;
  logic              in_valid;
  logic              in_ready;
  logic [NCH*IW-1:0] in_pix;
  logic [NCH-1:0]    ser_data;
  logic              ser_clk;
  logic              ser_latch;
  logic              disp_en;

  int n_tests;
  int n_fail;

  rgb_row_pwm_driver #(.COLS(COLS), .IW(IW), .NCH(NCH)) u_rgb_row_pwm_driver (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_pix(in_pix), .ser_data(ser_data), .ser_clk(ser_clk),
    .ser_latch(ser_latch), .disp_en(disp_en)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic int pix(int p, int c, int k);
    return (p + c + 8 * k - 16) & 255;
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  initial begin
    int in_pass, in_col, out_pass, released, nbits, low_cnt, cyc;
    bit vld_q, rdy_prev, prev_sclk, prev_oe, pend_after_rise;
    logic [NCH-1:0] prev_data;
    logic [COLS-1:0] cap [NCH];

    n_tests = 0; n_fail = 0;
    in_pass = 0; in_col = 0; out_pass = 0; released = 0;
    nbits = 0; low_cnt = 0; cyc = 0;
    vld_q = 0; rdy_prev = 0; prev_sclk = 0; prev_oe = 1;
    pend_after_rise = 0; prev_data = '0;
    for (int k = 0; k < NCH; k++) cap[k] = '0;

    rst_n = 1'b0; in_valid = 1'b0; in_pix = '0;
    repeat (3) @(negedge clk);
    // R9 outputs while reset is held
    check(disp_en == 1'b1 && ser_clk == 1'b0 && ser_latch == 1'b0 && ser_data == '0,
          "R9", {disp_en, ser_clk, ser_latch}, 4);
    rst_n = 1'b1;
    @(negedge clk);
    // R9 after release
    check(disp_en == 1'b1 && ser_clk == 1'b0 && ser_latch == 1'b0,
          "R9", {disp_en, ser_clk, ser_latch}, 4);
    check(in_ready == 1'b1, "R9", in_ready, 1);
    rdy_prev = in_ready;

    while (out_pass < NPASS && cyc < 100000) begin
      @(negedge clk);
      cyc++;
      // account for the handshake made at the edge just past
      if (vld_q && rdy_prev) begin
        in_col++;
        if (in_col == COLS) begin
          in_col = 0;
          in_pass++;
        end
      end

      // R10 minimal blanking gap
      if (pend_after_rise) check(disp_en == 1'b0, "R10", disp_en, 0);
      pend_after_rise = 0;

      if (disp_en && !prev_oe) begin
        released++;
        // R6 window length
        check(low_cnt == 2 * COLS + 1, "R6", low_cnt, 2 * COLS + 1);
        low_cnt = 0;
        if (in_pass - released >= 1) pend_after_rise = 1;
      end
      if (!disp_en) low_cnt++;

      if (ser_clk) begin
        // R6 blanked while shifting
        check(disp_en == 1'b0, "R6", disp_en, 0);
        // R5 low phase precedes high phase with same data
        check(!prev_sclk && ser_data == prev_data, "R5", ser_data, prev_data);
        // R4 whole pass captured before first bit
        if (nbits == 0) check(in_pass > out_pass, "R4", in_pass, out_pass + 1);
        if (nbits < COLS)
          for (int k = 0; k < NCH; k++) cap[k][nbits] = ser_data[k];
        nbits++;
      end

      if (ser_latch) begin
        // R7 latch placement and clock count
        check(prev_sclk && !disp_en, "R7", {prev_sclk, disp_en}, 2);
        check(nbits == COLS, "R7", nbits, COLS);
        for (int k = 0; k < NCH; k++) begin
          logic [COLS-1:0] exp;
          for (int c = 0; c < COLS; c++)
            exp[c] = (pix(out_pass, c, k) > (out_pass & 255));
          // R1 compare, R2 column order, R3 reference wrap
          check(cap[k] == exp, out_pass >= 256 ? "R3" : "R1/R2", int'(cap[k]), int'(exp));
        end
        out_pass++;
        nbits = 0;
      end

      // R8 backpressure
      check(in_ready == ((in_pass - released) < 2), "R8", in_ready,
            int'((in_pass - released) < 2));

      prev_sclk = ser_clk;
      prev_oe   = disp_en;
      prev_data = ser_data;

      if (in_pass < NPASS) begin
        vld_q    = (cyc % 7) != 3;
        in_valid = vld_q;
        for (int k = 0; k < NCH; k++) in_pix[k*IW +: IW] = IW'(pix(in_pass, in_col, k));
      end else begin
        vld_q    = 1'b0;
        in_valid = 1'b0;
      end
      rdy_prev = in_ready;
    end

    if (out_pass < NPASS) check(1'b0, "watchdog", out_pass, NPASS);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule